// File: doc/BRIEF.md
# Multi-frame HDLC transmit FIFO

This block is a byte-wide transmit buffer that holds several complete HDLC frames at once. The host writes frame bytes one at a time and then pulses a frame-close strobe. Each closed frame is recorded in a small table of end pointers and becomes eligible for transmission. Two pointers track byte positions: a write pointer that advances with every stored byte, and a read pointer that advances with every data byte sent. Two frame counters track frame boundaries: a write-frame counter that advances on each close, and a read-frame counter that advances as each frame finishes.

The line side pulls one byte per request strobe. The current byte is always presented on `out_data`, and `out_is_flag` marks the bytes that are flags, so a downstream bit stuffer can leave them alone. With no frame queued the block presents the flag 0x7E indefinitely. When a frame is queued, the next accepted flag acts as its opening flag. The frame data follows, then two check bytes, then a closing flag. If another frame is already queued, that closing flag doubles as its opening flag.

Both the buffer depth and the table size must be powers of two. The pointers and counters wrap modulo those sizes.

Top module: `hdlc_multiframe_txfifo`

## Requirements
- R1: A synchronous reset clears both byte pointers and both frame counters to zero. After reset, `out_data` is 0x7E, `out_is_flag` is 1 and `tab_full` is 0.
- R2: While no closed frame is pending, every accepted request gets the flag 0x7E with `out_is_flag`=1, and the read pointer and read-frame counter stay unchanged.
- R3: Data bytes of a frame leave in the order they were written, one per accepted request, with `out_is_flag`=0. They follow exactly one opening flag.
- R4: A close strobe makes the frame eligible for sending. A byte written in the same cycle as the close belongs to the frame being closed.
- R5: After the last data byte the block sends the two check bytes, then a closing flag. The check is the ones' complement of a CRC-16 with polynomial x^16+x^12+x^5+1, preset 0xFFFF, computed LSB-first (reflected constant 0x8408). The low byte goes first. Check bytes carry `out_is_flag`=0. The 9-byte ASCII frame "123456789" gives check bytes 0x6E then 0x90.
- R6: Queued frames are sent in close order. The closing flag of one frame is the opening flag of the next queued frame; no extra flag is sent between them.
- R7: A frame closed with no data bytes is sent as opening flag, check bytes 0x00 0x00, and closing flag.
- R8: At most FRAMES-1 closed frames may be pending. `tab_full` is 1 exactly when that many are pending, and a close strobe in that state is ignored.
- R9: The buffer holds at most DEPTH-1 unsent bytes. A write while the buffer is full is dropped.
- R10: In cycles without a request, the presented byte and the read position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| frame_done | input | 1 | Close the frame being written |
| tab_full | output | 1 | Frame table full (FRAMES-1 frames pending) |
| out_req | input | 1 | Line side accepts the presented byte |
| out_data | output | 8 | Presented byte |
| out_is_flag | output | 1 | Presented byte is a flag |

## Verification
The assertions check on every cycle that flag-marked bytes equal 0x7E, that idle requests leave the read pointer and read-frame counter alone, and that a close while the table is full or a write while the buffer is full changes nothing. They also check that each accepted data byte advances the read pointer by one and that reset clears all pointers. Only the bench scenarios can show whole byte streams: data order across queued frames, the check bytes against computed CRC values and the known nine-byte vector, empty frames, the exact count of frames kept when the table fills, and the exact number of bytes kept when the buffer overflows.

// File: rtl/hdlc_multiframe_txfifo.sv
module hdlc_multiframe_txfifo #(
  parameter int DEPTH  = 512,
  parameter int FRAMES = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       frame_done,
  output logic       tab_full,
  input  logic       out_req,
  output logic [7:0] out_data,
  output logic       out_is_flag
);
  localparam int ZW = $clog2(DEPTH);
  localparam int FW = $clog2(FRAMES);
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_FCS_LO, S_FCS_HI, S_CLOSE} st_t;

  st_t            st;
  logic [ZW-1:0]  z1, z2;
  logic [FW-1:0]  f1, f2;
  logic [15:0]    crc;
  logic [ZW-1:0]  z_end [FRAMES];
  logic [7:0]     buf_mem [DEPTH];

  wire [FW-1:0] pending  = f1 - f2;
  assign tab_full        = pending == FW'(FRAMES - 1);
  wire          buf_full = ZW'(z1 + 1'b1) == z2;
  wire          wr_ok    = wr_en && !buf_full;
  wire          close_ok = frame_done && !tab_full;
  wire [ZW-1:0] z1_nx    = z1 + ZW'(wr_ok);
  wire [ZW-1:0] z2_nx    = z2 + 1'b1;
  wire [FW-1:0] f2_nx    = f2 + 1'b1;
  wire [7:0]    cur      = buf_mem[z2];

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {1'b0, r[15:1]} ^ ((r[0] ^ d[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  always_comb begin
    out_is_flag = 1'b0;
    case (st)
      S_DATA:   out_data = cur;
      S_FCS_LO: out_data = ~crc[7:0];
      S_FCS_HI: out_data = ~crc[15:8];
      default: begin
        out_data    = FLAG;
        out_is_flag = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) buf_mem[z1] <= wr_data;
    if (close_ok) z_end[f1] <= z1_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z1 <= '0;
      f1 <= '0;
    end else begin
      z1 <= z1_nx;
      if (close_ok) f1 <= f1 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      z2  <= '0;
      f2  <= '0;
      crc <= 16'hFFFF;
    end else if (out_req) begin
      case (st)
        S_IDLE:
          if (f1 != f2) begin
            crc <= 16'hFFFF;
            st  <= (z2 == z_end[f2]) ? S_FCS_LO : S_DATA;
          end
        S_DATA: begin
          crc <= crc_step(crc, cur);
          z2  <= z2_nx;
          if (z2_nx == z_end[f2]) st <= S_FCS_LO;
        end
        S_FCS_LO: st <= S_FCS_HI;
        S_FCS_HI: st <= S_CLOSE;
        default: begin
          f2 <= f2_nx;
          if (f2_nx != f1) begin
            crc <= 16'hFFFF;
            st  <= (z2 == z_end[f2_nx]) ? S_FCS_LO : S_DATA;
          end else begin
            st <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module hdlc_txfifo_chk #(
  parameter int ZW = 9,
  parameter int FW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          frame_done,
  input logic          tab_full,
  input logic          out_req,
  input logic [7:0]    out_data,
  input logic          out_is_flag,
  input logic          idle,
  input logic          in_data,
  input logic [ZW-1:0] z1,
  input logic [ZW-1:0] z2,
  input logic [FW-1:0] f1,
  input logic [FW-1:0] f2
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (z1 == '0 && z2 == '0 && f1 == '0 && f2 == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && f1 == f2 && out_req) |=> (idle && $stable(f2) && $stable(z2)));

  // R5
  flag_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_is_flag |-> out_data == 8'h7E);

  // R3
  data_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_data && out_req) |=> z2 == ZW'($past(z2) + 1'b1));

  // R8
  tab_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tab_full && frame_done) |=> $stable(f1));

  // R9
  buf_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ZW'(z1 + 1'b1) == z2) |=> $stable(z1));

  // R10
  no_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_req |=> ($stable(z2) && $stable(f2)));
endmodule

bind hdlc_multiframe_txfifo hdlc_txfifo_chk #(.ZW(ZW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .frame_done(frame_done),
  .tab_full(tab_full), .out_req(out_req), .out_data(out_data),
  .out_is_flag(out_is_flag), .idle(st == S_IDLE), .in_data(st == S_DATA),
  .z1(z1), .z2(z2), .f1(f1), .f2(f2)
);

// File: tb/hdlc_multiframe_txfifo_test.sv
`timescale 1ns/1ps
module hdlc_multiframe_txfifo_test;
  localparam int DEPTH  = 512;
  localparam int FRAMES = 32;

  logic clk = 0, rst = 1, wr_en = 0, frame_done = 0, out_req = 0;
  logic [7:0] wr_data = 0;
  logic tab_full, out_is_flag;
  logic [7:0] out_data;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_d[$];
  bit exp_f[$];
  logic [15:0] acc;

  hdlc_multiframe_txfifo #(.DEPTH(DEPTH), .FRAMES(FRAMES)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .frame_done(frame_done), .tab_full(tab_full), .out_req(out_req),
    .out_data(out_data), .out_is_flag(out_is_flag));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] fcs_acc(input logic [15:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
      else c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit last);
    wr_en = 1; wr_data = b; frame_done = last;
    @(negedge clk);
    wr_en = 0; frame_done = 0;
  endtask

  task automatic close_frame();
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
  endtask

  task automatic expect_tail();
    exp_d.push_back(~acc[7:0]);  exp_f.push_back(0);
    exp_d.push_back(~acc[15:8]); exp_f.push_back(0);
    exp_d.push_back(8'h7E);      exp_f.push_back(1);
  endtask

  // frame of len bytes, pattern from seed; merge = close with last byte
  task automatic add_frame(input int len, input int seed, input bit merge);
    acc = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((seed * 37 + i * 13 + (i >> 3)) ^ seed);
      acc = fcs_acc(acc, b);
      exp_d.push_back(b); exp_f.push_back(0);
      put(b, merge && (i == len - 1));
    end
    if (!(merge && len > 0)) close_frame();
    expect_tail();
  endtask

  task automatic open_batch();
    exp_d.push_back(8'h7E); exp_f.push_back(1);
  endtask

  task automatic pull(input string tag);
    chk({tag, " data"}, 32'(out_data), 32'(exp_d[0]));
    chk({tag, " flag"}, 32'(out_is_flag), 32'(exp_f[0]));
    void'(exp_d.pop_front()); void'(exp_f.pop_front());
    out_req = 1;
    @(negedge clk);
    out_req = 0;
  endtask

  task automatic drain(input string tag);
    while (exp_d.size() > 0) pull(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 reset byte", 32'(out_data), 32'h7E);
    chk("R1 reset flag", 32'(out_is_flag), 1);
    chk("R1 reset tab_full", 32'(tab_full), 0);

    // R2 idle flags
    for (int i = 0; i < 5; i++) begin
      exp_d.push_back(8'h7E); exp_f.push_back(1);
      pull("R2 idle");
    end

    // R5 known vector "123456789"
    open_batch();
    acc = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin
      put(8'h31 + 8'(i), 0);
      exp_d.push_back(8'h31 + 8'(i)); exp_f.push_back(0);
    end
    close_frame();
    exp_d.push_back(8'h6E); exp_f.push_back(0);
    exp_d.push_back(8'h90); exp_f.push_back(0);
    exp_d.push_back(8'h7E); exp_f.push_back(1);
    drain("R5 vector");
    chk("R2 idle after frame", 32'(out_data), 32'h7E);

    // R3 R6 R7 sweep of lengths, three frames queued per batch
    for (int base = 0; base < 24; base += 3) begin
      open_batch();
      for (int k = 0; k < 3; k++) add_frame(base + k, base * 3 + k, 0);
      drain("R3 R6 R7 sweep");
    end

    // R7 lone empty frame
    open_batch();
    add_frame(0, 0, 0);
    drain("R7 empty");

    // R4 close in the same cycle as the last write
    open_batch();
    add_frame(5, 77, 1);
    add_frame(1, 91, 1);
    drain("R4 merged close");

    // R10 hold without request
    open_batch();
    add_frame(4, 5, 0);
    pull("R10 start");
    pull("R10 start");
    for (int i = 0; i < 6; i++) begin
      chk("R10 hold data", 32'(out_data), 32'(exp_d[0]));
      @(negedge clk);
    end
    drain("R10 rest");

    // R8 table full
    open_batch();
    for (int i = 0; i < FRAMES - 1; i++) begin
      chk("R8 not full", 32'(tab_full), 0);
      add_frame(0, 0, 0);
    end
    chk("R8 full", 32'(tab_full), 1);
    close_frame();
    chk("R8 still full", 32'(tab_full), 1);
    drain("R8 drain");
    chk("R8 extra close ignored", 32'(out_data), 32'h7E);
    chk("R8 extra close ignored flag", 32'(out_is_flag), 1);
    out_req = 1; @(negedge clk); out_req = 0;
    chk("R8 no extra frame", 32'(out_is_flag), 1);
    chk("R8 cleared", 32'(tab_full), 0);

    // R9 buffer overflow drops writes
    open_batch();
    acc = 16'hFFFF;
    for (int i = 0; i < DEPTH + 8; i++) begin
      logic [7:0] b;
      b = 8'(i * 7 + 3);
      put(b, 0);
      if (i < DEPTH - 1) begin
        acc = fcs_acc(acc, b);
        exp_d.push_back(b); exp_f.push_back(0);
      end
    end
    close_frame();
    expect_tail();
    drain("R9 overflow");
    chk("R9 idle after", 32'(out_is_flag), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule